// File: doc/BRIEF.md
# Link Port Serial Transmitter

This block sends 16-bit short words across a narrow source-synchronous link. It also drives the link's forwarded clock. The link is either four lanes wide or a single lane. A receiver captures one beat on every edge of the forwarded clock, both rising and falling. The block runs from a timing clock ("tick") at twice the core rate. The forwarded clock period is therefore a whole number of ticks for every ratio, including the fractional ratio of one and a half core periods.

Words arrive on a valid/ready interface. A word is taken only at a short-word boundary, and only while the receiver's acknowledge permits it. The acknowledge is seen through a delay window of sixteen link-clock periods. Because of this, a rising acknowledge releases the first clock edge after a fixed latency. A falling acknowledge halts the stream at a clean word boundary. A word can carry a "last of block" flag. That word raises a block-complete pulse shortly after it starts. The pulse lasts three word times.

The ratio and width selects may only change while the block is idle. Between transfers the forwarded clock and all data lanes rest low.

Top module: `link_tx`

## Requirements
- R1: While synchronous reset `rst` is high, and on the first tick after it, `link_clk`, `link_dat`, `blk_done` and `word_ready` are all 0.
- R2: The forwarded clock period P, in ticks, is 2, 3, 4 or 8 for `ratio_sel` values 0, 1, 2 and 3. These are ratios of 1, 1.5, 2 and 4 core periods.
- R3: Within a word the clock's high phase lasts ceil(P/2) ticks and its low phase lasts floor(P/2) ticks. For P=3 this gives 2 high and 1 low.
- R4: With `width_sel`=0, a word goes out as four nibbles on `link_dat[3:0]`, least significant nibble first. Beat k is captured on clock edge k, and edge 0 is the word's first rising edge. Each beat is already on the lanes one tick before its edge.
- R5: With `width_sel`=1, a word goes out as sixteen single bits on `link_dat[0]`, least significant bit first, while `link_dat[3:1]` stays 0.
- R6: A word occupies 2P ticks on the four-lane link and 8P ticks on the one-lane link. Words offered back to back while acknowledge stays high follow with no gap.
- R7: Suppose a word is waiting on an idle link and `ack_in` rises. The first rising edge of `link_clk` then comes exactly 16P ticks after the tick in which `ack_in` rose.
- R8: After `ack_in` falls, transmission halts at a word boundary. No partial word is sent, and no clock edge occurs until acknowledge returns.
- R9: While no word is being sent, `link_clk` and `link_dat` are held at 0.
- R10: `word_ready` is high only at a word boundary or when idle, and only while the delayed acknowledge permits. A word is taken exactly when `word_valid` and `word_ready` are both high at a tick edge, and its first beat starts on the next tick.
- R11: For a word taken with `word_last`=1, `blk_done` rises 2P ticks after that word's first rising clock edge. It then stays high for three word periods (3 × 2P or 3 × 8P ticks).
- R12: A reset in the middle of a word stops the clock at once. It also clears any pending acknowledge window, so no edge follows until acknowledge is seen again for the full latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock at twice the core rate (one tick) |
| rst | input | 1 | Synchronous active-high reset |
| ratio_sel | input | 2 | Clock ratio select: 0=1, 1=1.5, 2=2, 3=4 core periods |
| width_sel | input | 1 | Link width select: 0=four lanes, 1=one lane |
| word_valid | input | 1 | A short word is offered |
| word_data | input | 16 | Short word to send |
| word_last | input | 1 | Offered word ends a block |
| word_ready | output | 1 | Word is taken at this edge if valid |
| ack_in | input | 1 | Receiver acknowledge (flow control) |
| link_clk | output | 1 | Forwarded link clock |
| link_dat | output | 4 | Link data lanes |
| blk_done | output | 1 | Block-complete indication |

## Verification
The case that is hardest to reach from the ports is a stream halting at a word boundary once acknowledge drops. The acknowledge is honoured only after a delay of sixteen clock periods. The stop therefore lands several words after the stimulus, at a point the bench cannot steer directly. To reach it, the bench keeps a long queue of words offered, drops acknowledge while words are streaming, and waits out the delay window. It then checks three things: the clock is quiet, the lanes are low, and the scoreboard holds no half-delivered word. It then raises acknowledge again and measures the restart latency. The bench repeats this for every ratio and both widths, so the uneven 2/1 phase split at ratio 1.5 is exercised in both the streaming and the stopped state.

// File: rtl/link_tx_pkg.sv
package link_tx_pkg;

    typedef enum logic [1:0] {
        RATIO_1   = 2'd0,
        RATIO_1P5 = 2'd1,
        RATIO_2   = 2'd2,
        RATIO_4   = 2'd3
    } ratio_e;

    typedef enum logic {
        LANES_4 = 1'b0,
        LANES_1 = 1'b1
    } lanes_e;

    // longest forwarded-clock period in ticks
    localparam int MAX_PERIOD = 8;

    function automatic int period_ticks(ratio_e r);
        case (r)
            RATIO_1:   return 2;
            RATIO_1P5: return 3;
            RATIO_2:   return 4;
            default:   return 8;
        endcase
    endfunction

    function automatic int high_ticks(int p);
        return (p + 1) / 2;
    endfunction

    function automatic int low_ticks(int p);
        return p / 2;
    endfunction

    // ticks taken by one short word
    function automatic int word_ticks(int p, lanes_e l, int word_w, int lane_w);
        int beats;
        beats = (l == LANES_1) ? word_w : word_w / lane_w;
        return beats * p / 2;
    endfunction

endpackage

// File: rtl/link_tx_ackpipe.sv
module link_tx_ackpipe
    import link_tx_pkg::*;
#(
    parameter int ACK_MULT = 16
) (
    input  logic   clk,
    input  logic   rst,
    input  ratio_e ratio,
    input  logic   ack_in,
    output logic   ack_ok
);
    localparam int DEPTH = ACK_MULT * MAX_PERIOD - 2;
    localparam int IDX_W = $clog2(DEPTH);

    logic [DEPTH-1:0] hist;
    logic [IDX_W-1:0] tap;

    always_ff @(posedge clk) begin
        if (rst) hist <= '0;
        else     hist <= {hist[DEPTH-2:0], ack_in};
    end

    // three ticks are spent in the sampling flop, the take edge and the clock flop
    always_comb begin
        tap    = IDX_W'(ACK_MULT * period_ticks(ratio) - 3);
        ack_ok = hist[tap];
    end

endmodule

// File: rtl/link_tx_ser.sv
module link_tx_ser
    import link_tx_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int LANE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  ratio_e            ratio,
    input  lanes_e            lanes,
    input  logic              ack_ok,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              pclk,
    output logic [LANE_W-1:0] pdat,
    output logic              start_last
);
    localparam int BEATS_WIDE = WORD_W / LANE_W;
    localparam int BEAT_W     = $clog2(WORD_W);
    localparam int HALF_W     = $clog2(MAX_PERIOD);

    logic              busy;
    logic [HALF_W-1:0] tcnt;
    logic [BEAT_W-1:0] beat;
    logic [WORD_W-1:0] sreg;

    logic [HALF_W-1:0] half_len;
    logic [BEAT_W-1:0] last_beat;
    logic              half_end;
    logic              boundary;
    logic              take;

    always_comb begin
        half_len  = pclk ? HALF_W'(high_ticks(period_ticks(ratio)))
                         : HALF_W'(low_ticks(period_ticks(ratio)));
        last_beat = (lanes == LANES_1) ? BEAT_W'(WORD_W - 1) : BEAT_W'(BEATS_WIDE - 1);
        half_end  = busy && ((tcnt + HALF_W'(1)) == half_len);
        boundary  = !busy || (half_end && (beat == last_beat));
        in_ready  = boundary && ack_ok;
        take      = in_ready && in_valid;
        start_last = take && in_last;
    end

    generate
        if (LANE_W > 1) begin : g_multi
            always_comb
                pdat = (lanes == LANES_1) ? {{(LANE_W-1){1'b0}}, sreg[0]} : sreg[LANE_W-1:0];
        end else begin : g_single
            always_comb pdat = sreg[0];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            pclk <= 1'b0;
            tcnt <= '0;
            beat <= '0;
            sreg <= '0;
        end else if (take) begin
            busy <= 1'b1;
            pclk <= 1'b1;
            tcnt <= '0;
            beat <= '0;
            sreg <= in_data;
        end else if (boundary) begin
            busy <= 1'b0;
            pclk <= 1'b0;
            tcnt <= '0;
            beat <= '0;
            sreg <= '0;
        end else if (half_end) begin
            pclk <= !pclk;
            tcnt <= '0;
            beat <= beat + BEAT_W'(1);
            sreg <= (lanes == LANES_1) ? (sreg >> 1) : (sreg >> LANE_W);
        end else begin
            tcnt <= tcnt + HALF_W'(1);
        end
    end

    // R10
    take_starts_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (busy && pclk && beat == '0));

    // R9
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!pclk && pdat == '0));

    // R3
    split_high_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(pclk) && ratio == RATIO_1P5) |=> pclk);

    // R3
    split_low_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(pclk) && ratio == RATIO_1P5) |=> (pclk || !busy));

    // R2
    fast_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && ratio == RATIO_1) |-> (pclk != $past(pclk)));

endmodule

// File: rtl/link_tx_done.sv
module link_tx_done
    import link_tx_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int LANE_W = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  ratio_e ratio,
    input  lanes_e lanes,
    input  logic   start_last,
    output logic   done
);
    localparam int DLY_W  = $clog2(2 * MAX_PERIOD + 2);
    localparam int HOLD_W = $clog2(3 * WORD_W * MAX_PERIOD / 2 + 1);

    logic [DLY_W-1:0]  dly;
    logic [HOLD_W-1:0] hold;
    logic              fire;
    logic [DLY_W-1:0]  dly_load;
    logic [HOLD_W-1:0] hold_load;

    always_comb begin
        dly_load  = DLY_W'(2 * period_ticks(ratio) + 1);
        hold_load = HOLD_W'(3 * word_ticks(period_ticks(ratio), lanes, WORD_W, LANE_W));
        fire      = (dly == DLY_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dly  <= '0;
            hold <= '0;
            done <= 1'b0;
        end else begin
            if (start_last)        dly <= dly_load;
            else if (dly != '0)    dly <= dly - DLY_W'(1);

            if (fire) begin
                done <= 1'b1;
                hold <= hold_load;
            end else if (done) begin
                if (hold == HOLD_W'(1)) begin
                    done <= 1'b0;
                    hold <= '0;
                end else begin
                    hold <= hold - HOLD_W'(1);
                end
            end
        end
    end

    // R11
    done_width_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |=> done);

endmodule

// File: rtl/link_tx.sv
module link_tx
    import link_tx_pkg::*;
#(
    parameter int WORD_W   = 16,
    parameter int LANE_W   = 4,
    parameter int ACK_MULT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        ratio_sel,
    input  logic              width_sel,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    input  logic              word_last,
    output logic              word_ready,
    input  logic              ack_in,
    output logic              link_clk,
    output logic [LANE_W-1:0] link_dat,
    output logic              blk_done
);
    ratio_e ratio;
    lanes_e lanes;
    logic   ack_ok;
    logic   pclk;
    logic   start_last;

    always_comb begin
        ratio = ratio_e'(ratio_sel);
        lanes = lanes_e'(width_sel);
    end

    link_tx_ackpipe #(.ACK_MULT(ACK_MULT)) u_ack (
        .clk    (clk),
        .rst    (rst),
        .ratio  (ratio),
        .ack_in (ack_in),
        .ack_ok (ack_ok)
    );

    link_tx_ser #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_ser (
        .clk        (clk),
        .rst        (rst),
        .ratio      (ratio),
        .lanes      (lanes),
        .ack_ok     (ack_ok),
        .in_valid   (word_valid),
        .in_data    (word_data),
        .in_last    (word_last),
        .in_ready   (word_ready),
        .pclk       (pclk),
        .pdat       (link_dat),
        .start_last (start_last)
    );

    link_tx_done #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_done (
        .clk        (clk),
        .rst        (rst),
        .ratio      (ratio),
        .lanes      (lanes),
        .start_last (start_last),
        .done       (blk_done)
    );

    // forwarded clock trails the data by one tick so each beat settles first
    always_ff @(posedge clk) begin
        if (rst) link_clk <= 1'b0;
        else     link_clk <= pclk;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!link_clk && link_dat == '0 && !blk_done));

endmodule

// File: tb/test_link_tx.sv
module test_link_tx;
    localparam int TCLK = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  ratio_sel = 2'd0;
    logic        width_sel = 1'b0;
    logic        word_valid = 1'b0;
    logic [15:0] word_data = '0;
    logic        word_last = 1'b0;
    logic        word_ready;
    logic        ack_in = 1'b0;
    logic        link_clk;
    logic [3:0]  link_dat;
    logic        blk_done;

    link_tx i_link_tx (
        .clk        (clk),
        .rst        (rst),
        .ratio_sel  (ratio_sel),
        .width_sel  (width_sel),
        .word_valid (word_valid),
        .word_data  (word_data),
        .word_last  (word_last),
        .word_ready (word_ready),
        .ack_in     (ack_in),
        .link_clk   (link_clk),
        .link_dat   (link_dat),
        .blk_done   (blk_done)
    );

    always #(TCLK/2) clk = !clk;

    int total = 0;
    int bad = 0;
    bit ended = 0;
    int tick = 0;

    // configuration seen by the scoreboard
    int cur_p = 2, cur_h = 1, cur_l = 1, cur_bpw = 4, cur_w = 4;

    logic [3:0] exp_q[$];
    int         ws_q[$];
    int         edge_cnt = 0;
    int         done_rise = -1, done_fall = -1;
    bit         drv_done = 0;

    always @(posedge clk) tick <= tick + 1;

    task automatic chk(bit ok, string req, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // driver: offers one word, records its expected beats once it is taken
    task automatic send(logic [15:0] w, logic last);
        word_valid = 1'b1;
        word_data  = w;
        word_last  = last;
        while (!word_ready) @(negedge clk);
        if (cur_bpw == 4) begin
            for (int i = 0; i < 4; i++) exp_q.push_back(w[4*i +: 4]);
        end else begin
            for (int i = 0; i < 16; i++) exp_q.push_back({3'b000, w[i]});
        end
        @(negedge clk);
        word_valid = 1'b0;
        word_last  = 1'b0;
    endtask

    // monitor: acts as the receiver, capturing the beat on each forwarded-clock edge
    logic       prev_clk = 1'b0;
    logic [3:0] prev_dat = '0;
    logic       prev_done = 1'b0;
    int         idx = 0;
    int         last_rise = 0, last_fall = 0;

    always @(negedge clk) begin
        if (rst) begin
            idx = 0;
            prev_clk = 1'b0;
            prev_dat = '0;
            prev_done = 1'b0;
        end else begin
            if (link_clk !== prev_clk) begin
                edge_cnt++;
                if (link_clk) begin
                    if (idx == 0) ws_q.push_back(tick);
                    else begin
                        chk(tick - last_fall == cur_l, "R3 low phase", tick - last_fall, cur_l);
                        chk(tick - last_rise == cur_p, "R2 clock period", tick - last_rise, cur_p);
                    end
                    last_rise = tick;
                end else begin
                    chk(tick - last_rise == cur_h, "R3 high phase", tick - last_rise, cur_h);
                    last_fall = tick;
                end
                if (exp_q.size() == 0) begin
                    chk(0, "R4/R5 unexpected beat", prev_dat, -1);
                end else begin
                    logic [3:0] e;
                    e = exp_q.pop_front();
                    if (cur_bpw == 4) chk(prev_dat == e, "R4 nibble beat", prev_dat, e);
                    else              chk(prev_dat == e, "R5 bit beat", prev_dat, e);
                end
                idx = (idx + 1) % cur_bpw;
            end
            if (blk_done && !prev_done) done_rise = tick;
            if (!blk_done && prev_done) done_fall = tick;
            prev_clk = link_clk;
            prev_dat = link_dat;
            prev_done = blk_done;
        end
    end

    task automatic do_reset(int r, int l);
        @(negedge clk);
        rst = 1'b1;
        ack_in = 1'b0;
        word_valid = 1'b0;
        ratio_sel = 2'(r);
        width_sel = l[0];
        cur_p = (r == 0) ? 2 : (r == 1) ? 3 : (r == 2) ? 4 : 8;
        cur_h = (cur_p + 1) / 2;
        cur_l = cur_p / 2;
        cur_bpw = (l != 0) ? 16 : 4;
        cur_w = cur_bpw * cur_p / 2;
        repeat (3) @(negedge clk);
        exp_q.delete();
        ws_q.delete();
        rst = 1'b0;
        @(negedge clk);
        // R1 state right after reset
        chk(link_clk == 0 && link_dat == 0, "R1 link idle after reset", {link_clk, link_dat}, 0);
        chk(blk_done == 0 && word_ready == 0, "R1 done/ready after reset", {blk_done, word_ready}, 0);
    endtask

    task automatic run_cfg(int r, int l);
        int ta;
        int e0;
        do_reset(r, l);
        done_rise = -1;
        done_fall = -1;
        drv_done = 0;
        fork
            begin
                send(16'hA5C3, 1'b0);
                send(16'h1E7B, 1'b0);
                send(16'h6F90, 1'b1);
                drv_done = 1;
            end
        join_none
        ack_in = 1'b1;
        ta = tick;
        wait (drv_done);
        repeat (2 * cur_p + 3 * cur_w + 4 * cur_w + 10) @(negedge clk);
        chk(ws_q.size() == 3, "R6 word count", ws_q.size(), 3);
        if (ws_q.size() == 3) begin
            chk(ws_q[0] - ta == 16 * cur_p, "R7 ack rise latency", ws_q[0] - ta, 16 * cur_p);
            chk(ws_q[1] - ws_q[0] == cur_w, "R6 back-to-back period", ws_q[1] - ws_q[0], cur_w);
            chk(ws_q[2] - ws_q[1] == cur_w, "R6 back-to-back period", ws_q[2] - ws_q[1], cur_w);
            chk(done_rise - ws_q[2] == 2 * cur_p, "R11 done delay", done_rise - ws_q[2], 2 * cur_p);
        end
        chk(done_fall - done_rise == 3 * cur_w, "R11 done width", done_fall - done_rise, 3 * cur_w);
        chk(exp_q.size() == 0, "R4/R5 all beats delivered", exp_q.size(), 0);
        chk(link_clk == 0 && link_dat == 0, "R9 idle low", {link_clk, link_dat}, 0);

        // halt under flow control
        ws_q.delete();
        drv_done = 0;
        fork
            begin
                for (int k = 0; k < 12; k++) send(16'h3000 + 16'(k * 16'h0519), 1'b0);
                drv_done = 1;
            end
        join_none
        @(negedge clk);
        ack_in = 1'b0;
        repeat (16 * cur_p + cur_w + 4) @(negedge clk);
        e0 = edge_cnt;
        repeat (2 * cur_w + 4) @(negedge clk);
        chk(edge_cnt == e0, "R8 no edges while halted", edge_cnt - e0, 0);
        chk(exp_q.size() == 0, "R8 halt on word boundary", exp_q.size(), 0);
        chk(drv_done == 0, "R8 words still pending", drv_done, 0);
        chk(word_ready == 0, "R10 ready low while halted", word_ready, 0);
        chk(link_clk == 0 && link_dat == 0, "R9 lanes low while halted", {link_clk, link_dat}, 0);
        ws_q.delete();
        ack_in = 1'b1;
        ta = tick;
        wait (drv_done);
        repeat (cur_w + 6) @(negedge clk);
        chk(ws_q.size() > 0, "R7 restart happened", ws_q.size(), 1);
        if (ws_q.size() > 0)
            chk(ws_q[0] - ta == 16 * cur_p, "R7 restart latency", ws_q[0] - ta, 16 * cur_p);
        chk(exp_q.size() == 0, "R4/R5 stream drained", exp_q.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired (all requirements) actual=%0d expected=%0d", tick, 0);
        summary();
    end

    initial begin
        int e1;
        for (int r = 0; r < 4; r++)
            for (int l = 0; l < 2; l++)
                run_cfg(r, l);

        // R12 reset in the middle of a word
        do_reset(1, 1);
        drv_done = 0;
        fork
            begin
                send(16'hBEEF, 1'b0);
                drv_done = 1;
            end
        join_none
        ack_in = 1'b1;
        repeat (16 * cur_p + 4) @(negedge clk);
        chk(drv_done == 1, "R12 word under way", drv_done, 1);
        rst = 1'b1;
        @(negedge clk);
        chk(link_clk == 0 && link_dat == 0 && blk_done == 0, "R12 stopped by reset",
            {link_clk, link_dat, blk_done}, 0);
        @(negedge clk);
        rst = 1'b0;
        exp_q.delete();
        e1 = edge_cnt;
        repeat (10) @(negedge clk);
        chk(edge_cnt == e1, "R12 no edges after reset", edge_cnt - e1, 0);
        chk(word_ready == 0, "R12 ack window cleared", word_ready, 0);
        summary();
    end

endmodule